// File: doc/BRIEF.md
# Cacheability Decoder with DMA Invalidate Request

This block sits next to a 32-bit processor that has an on-chip cache and drives that processor's active-low cache-inhibit input. The processor is attached to a host system with a 24-bit address space. The decision is made again on every bus cycle from the cycle's address and function code. It is never latched per page or per region.

The inputs to that decision are a fixed system map and a table of per-slot window descriptors. Software writes those descriptors through a small synchronous register port.

- **Uncacheable:**
  - Memory that the host's custom chips can write.
  - I/O space.
  - CPU-space cycles.
  - Expansion windows marked as non-memory.
  - Any address that no region claims.
- **Cacheable:**
  - The processor card's own memory.
  - The relocatable 512 KB block at 0xC00000.
  - Expansion windows marked as plain memory.

The block also watches the expansion-bus DMA grant. When a grant ends, it raises a one-clock invalidate request so the cache can be flushed after DMA has written memory behind the processor's back. A global enable bit is cleared at reset and keeps every cycle uncacheable until software sets it.

Top module: `cache_attr_ctl`

## Requirements
- R1: While `as_n` is high, `cinh_n` is high (inactive), whatever the address, function code or configuration.
- R2: The global enable is `reg_wdata[0]` written to register index 8. It is 0 after reset. While it is 0, every strobed cycle gives `cinh_n` = 0, including cycles to otherwise cacheable memory.
- R3: A strobed cycle with `fc` = 3'b111 (CPU space) gives `cinh_n` = 0.
- R4: A strobed cycle whose address bits 23, 22 and 21 are all zero (0x000000–0x1FFFFF, custom-chip-writable RAM) gives `cinh_n` = 0. This holds even if a slot window covers that range.
- R5: Strobed cycles to 0xD00000–0xDFFFFF or 0xE80000–0xEFFFFF (I/O space) give `cinh_n` = 0. This holds even if a memory slot window covers them.
- R6: With the enable set, the relocated block 0xC00000–0xC7FFFF is cacheable (`cinh_n` = 1).
- R7: With the enable set, the processor card's own memory window 0x200000–0x3FFFFF is cacheable.
- R8: Slot register index i (0..7) takes `reg_wdata` with these fields:
  - bits [3:0]: base nibble.
  - bits [7:4]: mask nibble.
  - bit 8: 1 = memory, 0 = I/O.
  - bit 9: valid.

  A valid slot claims an address when `((addr[23:20] ^ base) & mask) == 0`. A claimed address is cacheable if the slot's memory bit is 1 and uncacheable if it is 0. The lowest-indexed claiming slot wins, and invalid slots claim nothing.
- R9: A strobed address that no region or slot claims gives `cinh_n` = 0.
- R10: Each high-to-low transition of `dma_grant` produces exactly one `inval_req` pulse, one clock long. The pulse is high in the cycle after the first clock edge that samples the grant low. Back-to-back grants separated by a single low cycle each produce their own pulse.
- R11: `cinh_n` is combinational in the current cycle's address. Consecutive cycles to different regions each get their own value with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 24 | Bus cycle address |
| as_n | input | 1 | Active-low address strobe |
| fc | input | 3 | Processor function code |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index: 0..7 slots, 8 control |
| reg_wdata | input | 10 | Register write data |
| dma_grant | input | 1 | Expansion-bus DMA grant, high while DMA owns the bus |
| cinh_n | output | 1 | Active-low cache inhibit for the current cycle |
| inval_req | output | 1 | One-clock cache invalidate request |

## Verification
The decoder is driven with addresses placed just inside and just outside each fixed region, such as 0x1FFFFF against 0x200000 and 0xC7FFFF against 0xC80000. This shows that each boundary sits on the intended address bit.

Slot windows are then programmed so that they overlap each other, the I/O ranges and unclaimed space. These cases separate the following:
- the priority between a fixed-map rule and a slot,
- the priority between two slots,
- the effect of the mask in widening a window,
- the effect of the memory attribute,
- the effect of the valid bit.

The enable bit, CPU-space cycles and an idle strobe are each applied to an address that would otherwise be cacheable, so that only the rule under test can explain the result. The DMA grant follows a pattern containing a long grant, back-to-back single-cycle grants and quiet stretches. This checks pulse timing and pulse count independently of the address decode.

// File: rtl/cache_attr_ctl.sv
module cache_attr_ctl #(
  parameter int AW = 24,
  parameter int FCW = 3,
  parameter int NSLOT = 8,
  parameter int RAW = 4,
  parameter int RDW = 10,
  parameter logic [3:0] LOCAL_BASE = 4'h2,
  parameter logic [3:0] LOCAL_MASK = 4'hE
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [AW-1:0]  addr,
  input  logic           as_n,
  input  logic [FCW-1:0] fc,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [RDW-1:0] reg_wdata,
  input  logic           dma_grant,
  output logic           cinh_n,
  output logic           inval_req
);

  localparam logic [RAW-1:0] CTL_IDX = RAW'(NSLOT);
  localparam logic [FCW-1:0] FC_CPU  = '1;

  logic [3:0] slot_base [NSLOT];
  logic [3:0] slot_mask [NSLOT];
  logic       slot_mem  [NSLOT];
  logic       slot_vld  [NSLOT];
  logic       cache_en;
  logic       grant_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cache_en <= 1'b0;
      for (int i = 0; i < NSLOT; i++) begin
        slot_base[i] <= '0;
        slot_mask[i] <= '0;
        slot_mem[i]  <= 1'b0;
        slot_vld[i]  <= 1'b0;
      end
    end else if (reg_we) begin
      if (reg_addr == CTL_IDX) cache_en <= reg_wdata[0];
      for (int i = 0; i < NSLOT; i++) begin
        if (reg_addr == RAW'(i)) begin
          slot_base[i] <= reg_wdata[3:0];
          slot_mask[i] <= reg_wdata[7:4];
          slot_mem[i]  <= reg_wdata[8];
          slot_vld[i]  <= reg_wdata[9];
        end
      end
    end
  end

  wire [3:0] top_nib = addr[AW-1 -: 4];

  logic [NSLOT-1:0] slot_hit;
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign slot_hit[g] = slot_vld[g] && (((top_nib ^ slot_base[g]) & slot_mask[g]) == 4'h0);
  end

  logic slot_any, slot_is_mem;
  always_comb begin
    slot_any = 1'b0;
    slot_is_mem = 1'b0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (slot_hit[i]) begin
        slot_any = 1'b1;
        slot_is_mem = slot_mem[i];
      end
    end
  end

  wire is_chip  = addr[AW-1 -: 3] == 3'b000;
  wire is_io    = (top_nib == 4'hD) || (addr[AW-1 -: 5] == 5'b11101);
  wire is_reloc = addr[AW-1 -: 5] == 5'b11000;
  wire is_local = ((top_nib ^ LOCAL_BASE) & LOCAL_MASK) == 4'h0;
  wire map_ok   = is_reloc || is_local || (slot_any && slot_is_mem);

  wire inhibit = !cache_en || (fc == FC_CPU) || is_chip || is_io || !map_ok;

  assign cinh_n = as_n || !inhibit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q   <= 1'b0;
      inval_req <= 1'b0;
    end else begin
      grant_q   <= dma_grant;
      inval_req <= grant_q && !dma_grant;
    end
  end

endmodule

module cache_attr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [23:0] addr,
  input logic        as_n,
  input logic [2:0]  fc,
  input logic        dma_grant,
  input logic        cinh_n,
  input logic        inval_req,
  input logic        cache_en
);

  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> cinh_n);

  p_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !cache_en) |-> !cinh_n);

  p_cpu_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && fc == 3'b111) |-> !cinh_n);

  p_chip_ram_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && addr[23:21] == 3'b000) |-> !cinh_n);

  p_io_space_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && (addr[23:20] == 4'hD || addr[23:19] == 5'b11101)) |-> !cinh_n);

  p_pulse_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inval_req |=> !inval_req);

  p_pulse_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    inval_req |-> (!$past(dma_grant) && $past(dma_grant, 2)));

endmodule

bind cache_attr_ctl cache_attr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .as_n(as_n), .fc(fc),
  .dma_grant(dma_grant), .cinh_n(cinh_n), .inval_req(inval_req),
  .cache_en(cache_en)
);

// File: tb/cache_attr_ctl_bench.sv
module cache_attr_ctl_bench;
  logic clk = 0, rst_n = 0;
  logic [23:0] addr = '0;
  logic as_n = 1;
  logic [2:0] fc = 3'd5;
  logic reg_we = 0;
  logic [3:0] reg_addr = '0;
  logic [9:0] reg_wdata = '0;
  logic dma_grant = 0;
  logic cinh_n, inval_req;

  cache_attr_ctl u_cache_attr_ctl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .as_n(as_n), .fc(fc),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .dma_grant(dma_grant), .cinh_n(cinh_n), .inval_req(inval_req)
  );

  always #10 clk = ~clk;

  typedef struct { logic c; logic i; string tag; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  logic h1 = 0, h2 = 0;
  bit done = 0;

  task automatic shift_hist();
    h2 = h1;
    h1 = dma_grant;
  endtask

  task automatic step(input logic [23:0] a, input logic [2:0] f, input logic s,
                      input logic g, input logic exp_c, input string tag);
    item_t it;
    @(negedge clk);
    reg_we = 0; addr = a; fc = f; as_n = s; dma_grant = g;
    it.c = exp_c; it.i = h2 & ~h1; it.tag = tag;
    q.push_back(it);
    shift_hist();
  endtask

  task automatic wr(input logic [3:0] idx, input logic [9:0] d);
    @(negedge clk);
    as_n = 1; reg_we = 1; reg_addr = idx; reg_wdata = d;
    shift_hist();
    @(negedge clk);
    reg_we = 0;
    shift_hist();
  endtask

  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (cinh_n !== it.c || inval_req !== it.i) begin
          errors++;
          $display("FAIL %s: cinh_n=%b inval_req=%b expected cinh_n=%b inval_req=%b",
                   it.tag, cinh_n, inval_req, it.c, it.i);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(24'h000000, 3'd5, 1, 0, 1, "R1 reset idle strobe");
    step(24'hC00000, 3'd5, 0, 0, 0, "R2 reset enable clear");
    step(24'h200000, 3'd5, 0, 0, 0, "R2 local while disabled");
    wr(4'd8, 10'h001);
    step(24'hC00000, 3'd5, 0, 0, 1, "R6 reloc base");
    step(24'hC7FFFF, 3'd5, 0, 0, 1, "R6 reloc top");
    step(24'hC80000, 3'd5, 0, 0, 0, "R9 above reloc");
    step(24'h000000, 3'd5, 0, 0, 0, "R4 chip base");
    step(24'h1FFFFF, 3'd5, 0, 0, 0, "R4 chip top");
    step(24'h200000, 3'd5, 0, 0, 1, "R7 local base");
    step(24'h3FFFFF, 3'd5, 0, 0, 1, "R7 local top");
    step(24'h000000, 3'd5, 0, 0, 0, "R11 back to chip");
    step(24'h200000, 3'd5, 0, 0, 1, "R11 back to local");
    step(24'h400000, 3'd5, 0, 0, 0, "R9 unclaimed");
    step(24'h200000, 3'd7, 0, 0, 0, "R3 cpu space");
    step(24'h200000, 3'd1, 1, 0, 1, "R1 idle on local");
    step(24'hD00000, 3'd5, 0, 0, 0, "R5 io D base");
    step(24'hDFFFFF, 3'd5, 0, 0, 0, "R5 io D top");
    step(24'hE80000, 3'd5, 0, 0, 0, "R5 io E8 base");
    step(24'hEFFFFF, 3'd5, 0, 0, 0, "R5 io EF top");
    wr(4'd0, 10'h3F4);
    step(24'h400000, 3'd5, 0, 0, 1, "R8 slot0 mem base");
    step(24'h4FFFFF, 3'd5, 0, 0, 1, "R8 slot0 mem top");
    step(24'h500000, 3'd5, 0, 0, 0, "R8 slot0 outside");
    wr(4'd1, 10'h3E6);
    step(24'h600000, 3'd5, 0, 0, 1, "R8 slot1 mask low");
    step(24'h7FFFFF, 3'd5, 0, 0, 1, "R8 slot1 mask high");
    step(24'h800000, 3'd5, 0, 0, 0, "R8 slot1 outside mask");
    wr(4'd2, 10'h2F6);
    step(24'h600000, 3'd5, 0, 0, 1, "R8 lower slot wins");
    wr(4'd0, 10'h2F4);
    step(24'h400000, 3'd5, 0, 0, 0, "R8 slot0 io attr");
    wr(4'd3, 10'h3FE);
    step(24'hE00000, 3'd5, 0, 0, 1, "R8 slot3 mem E");
    step(24'hE80000, 3'd5, 0, 0, 0, "R5 io over mem slot");
    wr(4'd5, 10'h3F0);
    step(24'h000000, 3'd5, 0, 0, 0, "R4 chip over mem slot");
    wr(4'd4, 10'h1F9);
    step(24'h900000, 3'd5, 0, 0, 0, "R8 invalid slot");
    wr(4'd7, 10'h3FA);
    step(24'hA00000, 3'd5, 0, 0, 1, "R8 slot7 mem");
    step(24'hA00000, 3'd7, 0, 0, 0, "R3 cpu space in slot");
    wr(4'd8, 10'h000);
    step(24'hA00000, 3'd5, 0, 0, 0, "R2 disabled slot");
    wr(4'd8, 10'h001);
    step(24'hA00000, 3'd5, 0, 0, 1, "R2 re-enabled");
    begin
      logic pat [14] = '{0,1,1,1,0,0,0,1,0,1,0,0,0,0};
      foreach (pat[k]) step(24'hC00000, 3'd5, 0, pat[k], 1, "R10 grant pattern");
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule